// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block is a synchronous controller that follows a processor core through its clock-control power states. There are five: running, halted with clocks alive, stop-grant, sleep and deep sleep. A core HALT event, a wake or interrupt event, an active-low stop request, an active-low sleep request and an active-low core reset move it between these states. A "bus clock stopped" flag stands in for the physical stopping of the bus clock, so the whole block stays on one running clock.

The controller reports its current state as a 3-bit code. It also drives a snoop-enable flag, a core clock enable, a one-cycle acknowledge when stop-grant is entered, and a one-cycle sequencing-error pulse. The error pulse fires when sleep is left with the stop request released too early. The return path out of stop-grant depends on how stop-grant was entered. One stored bit records whether the core was running or halted when the stop request arrived.

Top module: `lp_state_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, with no request pending, `state_o` is 0 (running), `snoop_en_o` and `core_clk_en_o` are 1, and `stop_ack_o` and `seq_err_o` are 0.
- R2: In running (0), a sampled `halt_i` moves the state to halted (1) on the next edge. Halted keeps `snoop_en_o` and `core_clk_en_o` at 1. When `halt_i` and an asserted stop request arrive together, the stop request wins.
- R3: In halted (1), a sampled `wake_i` returns the state to running (0). With no event pending, halted holds.
- R4: An asserted stop request (`stop_req_ni` low) in running or halted moves the state to stop-grant (2). `stop_ack_o` is 1 exactly in the first cycle in which `state_o` shows 2. `core_clk_en_o` is 0 in states 2, 3 and 4.
- R5: Releasing the stop request in stop-grant returns the state to the state it came from: running (0) or halted (1).
- R6: In stop-grant, an asserted sleep request (`sleep_req_ni` low) moves the state to sleep (3), and its release returns the state to stop-grant (2) with no acknowledge. `snoop_en_o` is 0 in states 3 and 4 and 1 in states 0 to 2.
- R7: In sleep, `bclk_stopped_i` high moves the state to deep sleep (4), and its return to 0 moves the state back to sleep (3). In every other state `bclk_stopped_i` has no effect.
- R8: A sampled low `core_rst_ni` forces the state to stop-grant (2) from stop-grant, sleep or deep sleep, and to running (0) from running or halted. It also clears the stored origin, so the later release of the stop request leads to running even when stop-grant was first entered from halted.
- R9: If the sleep and stop requests are released in the same cycle while in sleep (with the bus clock running), `seq_err_o` is 1 for one cycle, in the same cycle that `state_o` shows 2. Releasing the stop request one or more cycles after the sleep request raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| halt_i | input | 1 | Core HALT event |
| wake_i | input | 1 | Interrupt or wake event |
| stop_req_ni | input | 1 | Active-low stop-clock request |
| sleep_req_ni | input | 1 | Active-low sleep request |
| core_rst_ni | input | 1 | Active-low synchronous core reset |
| bclk_stopped_i | input | 1 | High while the bus clock is considered stopped |
| state_o | output | 3 | State code: 0 run, 1 halted, 2 stop-grant, 3 sleep, 4 deep sleep |
| snoop_en_o | output | 1 | Snoops accepted |
| stop_ack_o | output | 1 | One-cycle stop-grant entry acknowledge |
| core_clk_en_o | output | 1 | Core clock enable |
| seq_err_o | output | 1 | One-cycle sleep-exit sequencing error |

## Verification
The assertions check on every cycle that the acknowledge appears only in stop-grant and never for two cycles in a row. They also check that halted keeps snoops enabled, that the core clock is off in the three stopped states, that deep sleep is only reached from sleep, and that an error pulse always follows a cycle in sleep. Only the bench's scenarios can show where stop-grant returns to after leaving sleep, which needs the origin bit. The same holds for the reset-in-sleep path that parks in stop-grant, the priority of the stop request over HALT, and the difference between a same-cycle release and a spaced release of the two requests.

// File: rtl/lp_state_pkg.sv
package lp_state_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN    = 3'd0,
    PS_HALT   = 3'd1,
    PS_STPGNT = 3'd2,
    PS_SLEEP  = 3'd3,
    PS_DEEP   = 3'd4
  } pstate_e;
endpackage

// File: rtl/lp_next_state.sv
module lp_next_state
  import lp_state_pkg::*;
(
  input  pstate_e cur_state_i,
  input  logic    org_halt_i,
  input  logic    halt_i,
  input  logic    wake_i,
  input  logic    stop_req_i,
  input  logic    sleep_req_i,
  input  logic    core_rst_i,
  input  logic    bclk_stopped_i,
  output pstate_e nxt_state_o,
  output logic    nxt_org_halt_o,
  output logic    grant_entry_o
);
  always_comb begin
    nxt_state_o    = cur_state_i;
    nxt_org_halt_o = org_halt_i;
    grant_entry_o  = 1'b0;
    if (core_rst_i) begin
      nxt_org_halt_o = 1'b0;
      if (cur_state_i == PS_STPGNT || cur_state_i == PS_SLEEP || cur_state_i == PS_DEEP)
        nxt_state_o = PS_STPGNT;
      else
        nxt_state_o = PS_RUN;
    end else begin
      case (cur_state_i)
        PS_RUN: begin
          if (stop_req_i) begin
            nxt_state_o    = PS_STPGNT;
            nxt_org_halt_o = 1'b0;
            grant_entry_o  = 1'b1;
          end else if (halt_i) begin
            nxt_state_o = PS_HALT;
          end
        end
        PS_HALT: begin
          if (stop_req_i) begin
            nxt_state_o    = PS_STPGNT;
            nxt_org_halt_o = 1'b1;
            grant_entry_o  = 1'b1;
          end else if (wake_i) begin
            nxt_state_o = PS_RUN;
          end
        end
        PS_STPGNT: begin
          if (!stop_req_i)
            nxt_state_o = org_halt_i ? PS_HALT : PS_RUN;
          else if (sleep_req_i)
            nxt_state_o = PS_SLEEP;
        end
        PS_SLEEP: begin
          if (bclk_stopped_i)
            nxt_state_o = PS_DEEP;
          else if (!sleep_req_i)
            nxt_state_o = PS_STPGNT;
        end
        PS_DEEP: begin
          if (!bclk_stopped_i)
            nxt_state_o = PS_SLEEP;
        end
        default: begin
          // unused codes fall back to running
          nxt_state_o    = PS_RUN;
          nxt_org_halt_o = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lp_seq_guard.sv
module lp_seq_guard
  import lp_state_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pstate_e cur_state_i,
  input  logic    stop_req_i,
  input  logic    sleep_req_i,
  input  logic    bclk_stopped_i,
  output logic    seq_err_o
);
  logic err_q;

  // both requests dropped in the same bus clock while leaving sleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (cur_state_i == PS_SLEEP) && !bclk_stopped_i
                          && !sleep_req_i && !stop_req_i;
  end

  assign seq_err_o = err_q;
endmodule

// File: rtl/lp_out_decode.sv
module lp_out_decode
  import lp_state_pkg::*;
(
  input  pstate_e state_i,
  output logic    snoop_en_o,
  output logic    core_clk_en_o
);
  always_comb begin
    snoop_en_o    = 1'b0;
    core_clk_en_o = 1'b0;
    case (state_i)
      PS_RUN, PS_HALT: begin
        snoop_en_o    = 1'b1;
        core_clk_en_o = 1'b1;
      end
      PS_STPGNT: snoop_en_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_state_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halt_i,
  input  logic               wake_i,
  input  logic               stop_req_ni,
  input  logic               sleep_req_ni,
  input  logic               core_rst_ni,
  input  logic               bclk_stopped_i,
  output logic [STATE_W-1:0] state_o,
  output logic               snoop_en_o,
  output logic               stop_ack_o,
  output logic               core_clk_en_o,
  output logic               seq_err_o
);
  pstate_e state_q, state_d;
  logic    org_halt_q, org_halt_d;
  logic    grant_entry, ack_q;
  logic    stop_req, sleep_req, core_rst;

  assign stop_req  = ~stop_req_ni;
  assign sleep_req = ~sleep_req_ni;
  assign core_rst  = ~core_rst_ni;

  lp_next_state u_next (
    .cur_state_i    (state_q),
    .org_halt_i     (org_halt_q),
    .halt_i         (halt_i),
    .wake_i         (wake_i),
    .stop_req_i     (stop_req),
    .sleep_req_i    (sleep_req),
    .core_rst_i     (core_rst),
    .bclk_stopped_i (bclk_stopped_i),
    .nxt_state_o    (state_d),
    .nxt_org_halt_o (org_halt_d),
    .grant_entry_o  (grant_entry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PS_RUN;
      org_halt_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      org_halt_q <= org_halt_d;
      ack_q      <= grant_entry;
    end
  end

  lp_seq_guard u_guard (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cur_state_i    (state_q),
    .stop_req_i     (stop_req),
    .sleep_req_i    (sleep_req),
    .bclk_stopped_i (bclk_stopped_i),
    .seq_err_o      (seq_err_o)
  );

  lp_out_decode u_dec (
    .state_i       (state_q),
    .snoop_en_o    (snoop_en_o),
    .core_clk_en_o (core_clk_en_o)
  );

  assign state_o    = state_q;
  assign stop_ack_o = ack_q;

  // R4
  ack_only_in_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ack_o |-> state_q == PS_STPGNT);

  // R4
  ack_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ack_o |=> !stop_ack_o);

  // R4
  clk_off_when_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_STPGNT || state_q == PS_SLEEP || state_q == PS_DEEP) |-> !core_clk_en_o);

  // R2
  snoop_in_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PS_HALT |-> snoop_en_o);

  // R7
  deep_from_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DEEP && $past(state_q) != PS_DEEP) |-> $past(state_q) == PS_SLEEP);

  // R9
  err_after_sleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> ($past(state_q) == PS_SLEEP && state_q == PS_STPGNT));
endmodule

// File: tb/lp_state_ctrl_bench.sv
module lp_state_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       halt_i = 1'b0, wake_i = 1'b0;
  logic       stop_req_ni = 1'b1, sleep_req_ni = 1'b1, core_rst_ni = 1'b1;
  logic       bclk_stopped_i = 1'b0;
  logic [2:0] state_o;
  logic       snoop_en_o, stop_ack_o, core_clk_en_o, seq_err_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic       ack;
    logic       err;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  lp_state_ctrl u_lp_state_ctrl (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .halt_i         (halt_i),
    .wake_i         (wake_i),
    .stop_req_ni    (stop_req_ni),
    .sleep_req_ni   (sleep_req_ni),
    .core_rst_ni    (core_rst_ni),
    .bclk_stopped_i (bclk_stopped_i),
    .state_o        (state_o),
    .snoop_en_o     (snoop_en_o),
    .stop_ack_o     (stop_ack_o),
    .core_clk_en_o  (core_clk_en_o),
    .seq_err_o      (seq_err_o)
  );

  // monitor: pops expectations and compares at the falling edge
  always @(negedge clk) begin
    exp_t e;
    logic snp, cen;
    if (q.size() > 0) begin
      e   = q.pop_front();
      snp = (e.st <= 3'd2);
      cen = (e.st <= 3'd1);
      tests++;
      if (state_o !== e.st || stop_ack_o !== e.ack || seq_err_o !== e.err ||
          snoop_en_o !== snp || core_clk_en_o !== cen) begin
        fails++;
        $display("FAIL %s: got st=%0d ack=%b err=%b snp=%b cen=%b exp st=%0d ack=%b err=%b snp=%b cen=%b",
                 e.tag, state_o, stop_ack_o, seq_err_o, snoop_en_o, core_clk_en_o,
                 e.st, e.ack, e.err, snp, cen);
      end
    end
  end

  // driver: applies one cycle of inputs and queues the result expected after the edge
  task automatic step(input logic h, input logic w, input logic sn, input logic sl,
                      input logic cr, input logic bs, input logic [2:0] st,
                      input logic ack, input logic err, input string tag);
    @(negedge clk);
    halt_i = h; wake_i = w; stop_req_ni = sn; sleep_req_ni = sl;
    core_rst_ni = cr; bclk_stopped_i = bs;
    @(posedge clk);
    #1;
    q.push_back('{st, ack, err, tag});
  endtask

  initial begin
    @(posedge clk);
    #1;
    q.push_back('{3'd0, 1'b0, 1'b0, "R1 in reset"});
    @(negedge clk);
    rst_ni = 1'b1;
    //    h  w  sn sl cr bs  st  ack err
    step(0, 0, 1, 1, 1, 0, 3'd0, 0, 0, "R1 idle after reset");
    step(1, 0, 1, 1, 1, 0, 3'd1, 0, 0, "R2 halt enters halted");
    step(0, 0, 1, 1, 1, 0, 3'd1, 0, 0, "R3 halted holds");
    step(0, 1, 1, 1, 1, 0, 3'd0, 0, 0, "R3 wake returns to run");
    step(1, 0, 0, 1, 1, 0, 3'd2, 1, 0, "R2 stop wins over halt / R4 ack");
    step(0, 0, 0, 1, 1, 0, 3'd2, 0, 0, "R4 ack one cycle");
    step(0, 0, 1, 1, 1, 0, 3'd0, 0, 0, "R5 return to run");
    step(1, 0, 1, 1, 1, 0, 3'd1, 0, 0, "R2 halt again");
    step(0, 0, 0, 1, 1, 0, 3'd2, 1, 0, "R4 grant from halted");
    step(0, 0, 0, 1, 1, 0, 3'd2, 0, 0, "R4 grant holds");
    step(0, 0, 1, 1, 1, 0, 3'd1, 0, 0, "R5 return to halted");
    step(0, 1, 1, 1, 1, 0, 3'd0, 0, 0, "R3 wake");
    step(0, 0, 1, 1, 1, 1, 3'd0, 0, 0, "R7 clock stop ignored in run");
    step(0, 0, 0, 1, 1, 0, 3'd2, 1, 0, "R4 grant");
    step(0, 0, 0, 0, 1, 0, 3'd3, 0, 0, "R6 sleep entry");
    step(0, 0, 0, 0, 1, 1, 3'd4, 0, 0, "R7 deep sleep entry");
    step(0, 0, 0, 0, 1, 1, 3'd4, 0, 0, "R7 deep sleep holds");
    step(0, 0, 0, 0, 1, 0, 3'd3, 0, 0, "R7 clock restart to sleep");
    step(0, 0, 0, 1, 1, 0, 3'd2, 0, 0, "R6 sleep exit no ack");
    step(0, 0, 1, 1, 1, 0, 3'd0, 0, 0, "R9 spaced release no error");
    step(0, 0, 0, 1, 1, 0, 3'd2, 1, 0, "R4 grant");
    step(0, 0, 0, 0, 1, 0, 3'd3, 0, 0, "R6 sleep");
    step(0, 0, 1, 1, 1, 0, 3'd2, 0, 1, "R9 same-cycle release error");
    step(0, 0, 1, 1, 1, 0, 3'd0, 0, 0, "R9 error one cycle");
    step(0, 0, 0, 1, 1, 0, 3'd2, 1, 0, "R4 grant");
    step(0, 0, 0, 0, 1, 0, 3'd3, 0, 0, "R6 sleep");
    step(0, 0, 0, 0, 0, 0, 3'd2, 0, 0, "R8 reset in sleep to grant");
    step(0, 0, 0, 1, 0, 0, 3'd2, 0, 0, "R8 reset held stays grant");
    step(0, 0, 0, 1, 1, 0, 3'd2, 0, 0, "R8 grant while stop held");
    step(0, 0, 1, 1, 1, 0, 3'd0, 0, 0, "R8 stop release to run");
    step(1, 0, 1, 1, 1, 0, 3'd1, 0, 0, "R2 halt");
    step(0, 0, 0, 1, 1, 0, 3'd2, 1, 0, "R4 grant from halted");
    step(0, 0, 0, 0, 1, 0, 3'd3, 0, 0, "R6 sleep");
    step(0, 0, 0, 0, 0, 0, 3'd2, 0, 0, "R8 reset in sleep");
    step(0, 0, 0, 1, 1, 0, 3'd2, 0, 0, "R8 grant after reset");
    step(0, 0, 1, 1, 1, 0, 3'd0, 0, 0, "R8 origin cleared to run");
    step(1, 0, 1, 1, 1, 0, 3'd1, 0, 0, "R2 halt");
    step(0, 0, 1, 1, 0, 0, 3'd0, 0, 0, "R8 reset in halted to run");
    step(0, 0, 1, 1, 1, 0, 3'd0, 0, 0, "R1 idle");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule